// File: doc/BRIEF.md
# Two-Bank Interleaved DRAM Strobe Sequencer

This block is a small state machine that drives the row strobes and the address-multiplexer controls for a DRAM array. The array is split into two interleaved banks that sit behind a 32-bit processor bus. Every register runs on a clock at twice the processor rate. A phase input marks each rising edge of that clock as one of two kinds. A start edge opens a processor clock, and a middle edge falls halfway through it. Both row strobes change only on start edges. The row/column select and the multiplexer enable change only on middle edges.

An access begins when every chip-select qualifier is low on a start edge. Address bit 2 picks the bank whose strobe falls. If the sequencer is busy, it holds one request in a pending flag and launches that request as soon as it is free. A refresh request is caught on a middle edge and wins the next free start edge. A refresh drops both strobes together and disables the address multiplexer. The direction input is sampled at the start of the second processor clock of an access, and a write holds the strobe for extra clocks. Every access and every refresh ends with a fixed precharge interval in which both strobes are high.

Top module: `dram_ilv_seq`

## Requirements
- R1: A request is recognised only at a start edge (phase_mid low at the rising edge) with all NSEL bits of sel_n low. A start edge with any select bit high launches nothing and sets no pending flag.
- R2: When a request cannot start at its own edge, pend_q rises after that edge. While pend_q is set, further requests are dropped. pend_q clears at the start edge that ends the first processor clock of the access launched from it.
- R3: An access pulls only the strobe of the chosen bank low. Bank 0 gives ras_n = 2'b10 and bank 1 gives ras_n = 2'b01. The bank is addr_b2 at the launch edge and is held in bank_q, unchanged, for the whole access.
- R4: ras_n changes only after start edges. row_sel and mux_en_n change only after middle edges.
- R5: refresh_req is sampled at middle edges and held until a refresh starts. The refresh starts at the first free start edge, ahead of any queued access, and drives ras_n = 2'b00 for REF_CLKS processor clocks.
- R6: row_sel is high (row) when a strobe falls. It goes low (column) from the next middle edge and stays low while the access lasts.
- R7: mux_en_n is high (multiplexer off) from the middle edge after a refresh starts until the middle edge after it ends. Otherwise it is low.
- R8: A read holds its strobe for ACC_CLKS processor clocks. If wr_dir is high at the start edge that opens the second clock, the strobe is held WR_EXTRA_CLKS clocks longer.
- R9: After each access or refresh, both strobes stay high for PRE_CLKS processor clocks before the next strobe can fall.
- R10: While rst is high at a rising edge, the block forces ras_n = 2'b11, row_sel = 1, mux_en_n = 0, bank_q = 0 and pend_q = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2 | input | 1 | Double-rate clock for every register |
| rst | input | 1 | Synchronous active-high reset |
| phase_mid | input | 1 | High marks the next rising edge as a middle edge, low as a start edge |
| sel_n | input | NSEL | Active-low chip-select qualifiers |
| wr_dir | input | 1 | Direction, high means write |
| addr_b2 | input | 1 | Address bit 2, bank choice |
| refresh_req | input | 1 | Refresh request from the interval counter |
| ras_n | output | 2 | Active-low row strobes, bit 0 for bank 0, bit 1 for bank 1 |
| row_sel | output | 1 | Multiplexer select, 1 = row address, 0 = column address |
| mux_en_n | output | 1 | Active-low address multiplexer enable |
| bank_q | output | 1 | Registered bank of the current or last access |
| pend_q | output | 1 | One-deep queued request flag |

## Verification
The bench builds the block with NSEL = 3, ACC_CLKS = 2, WR_EXTRA_CLKS = 1, REF_CLKS = 2 and PRE_CLKS = 1. With these values a read lasts four double-rate cycles, a write lasts six, and precharge lasts two. A second request can therefore land in the first clock of an access, and a refresh can land while an access is still queued. These settings keep the interactions between the queue, refresh priority and the write extension within a few dozen cycles. A long random run then mixes partial selects with those interactions.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ACT  = 2'b01,
        ST_RFR  = 2'b10,
        ST_PRE  = 2'b11
    } seq_st_e;

    typedef struct packed {
        logic s_edge;
        logic m_edge;
    } edge_t;

    localparam logic [1:0] RAS_ALL_OFF = 2'b11;
    localparam logic [1:0] RAS_ALL_ON  = 2'b00;

    // strobe pattern for a given sequencer state and bank
    function automatic logic [1:0] ras_pattern(seq_st_e st, logic bank);
        logic [1:0] p;
        case (st)
            ST_ACT:  p = bank ? 2'b01 : 2'b10;
            ST_RFR:  p = RAS_ALL_ON;
            default: p = RAS_ALL_OFF;
        endcase
        return p;
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dseq_req_queue.sv
module dseq_req_queue import dseq_pkg::*; #(
    parameter int NSEL = 5
) (
    input  logic            clk2,
    input  logic            rst,
    input  logic            s_edge,
    input  logic [NSEL-1:0] sel_n,
    input  logic            accept_now,
    input  logic            clr_now,
    output logic            req_now,
    output logic            pend_q
);

    assign req_now = s_edge && (sel_n == '0);

    always_ff @(posedge clk2) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (req_now && !pend_q && !accept_now) begin
            pend_q <= 1'b1;
        end else if (clr_now) begin
            pend_q <= 1'b0;
        end
    end

    // R2: a held request is not lost until its access is launched and aged
    assert_pend_holds_R2: assert property (@(posedge clk2) disable iff (rst)
        (pend_q && !clr_now) |=> pend_q);

    // R2: the clear point drops a set flag
    assert_pend_clears_R2: assert property (@(posedge clk2) disable iff (rst)
        (pend_q && clr_now) |=> !pend_q);

    // R1: nothing is queued away from a start edge
    assert_no_mid_queue_R1: assert property (@(posedge clk2) disable iff (rst)
        (!s_edge && !pend_q) |=> !pend_q);

endmodule

// File: rtl/dseq_ref_latch.sv
module dseq_ref_latch import dseq_pkg::*; (
    input  logic clk2,
    input  logic rst,
    input  logic m_edge,
    input  logic refresh_req,
    input  logic ref_take,
    output logic ref_pend
);

    always_ff @(posedge clk2) begin
        if (rst) begin
            ref_pend <= 1'b0;
        end else if (m_edge && refresh_req) begin
            ref_pend <= 1'b1;
        end else if (ref_take) begin
            ref_pend <= 1'b0;
        end
    end

    // R5: a request seen at a middle edge is remembered
    assert_ref_capture_R5: assert property (@(posedge clk2) disable iff (rst)
        (m_edge && refresh_req) |=> ref_pend);

    // R5: the latch only empties when the refresh is taken
    assert_ref_kept_R5: assert property (@(posedge clk2) disable iff (rst)
        (ref_pend && !ref_take) |=> ref_pend);

endmodule

// File: rtl/dseq_core.sv
module dseq_core import dseq_pkg::*; #(
    parameter int ACC_CLKS      = 2,
    parameter int WR_EXTRA_CLKS = 1,
    parameter int REF_CLKS      = 2,
    parameter int PRE_CLKS      = 1
) (
    input  logic    clk2,
    input  logic    rst,
    input  logic    s_edge,
    input  logic    req_now,
    input  logic    pend_q,
    input  logic    ref_pend,
    input  logic    addr_b2,
    input  logic    wr_dir,
    output seq_st_e st_q,
    output seq_st_e nxt_st,
    output logic    bank_q,
    output logic    nxt_bank,
    output logic    accept_now,
    output logic    clr_now,
    output logic    ref_take
);

    localparam int ACC_WR_CLKS = ACC_CLKS + WR_EXTRA_CLKS;
    localparam int MAX_CLKS    = max3(ACC_WR_CLKS, REF_CLKS, PRE_CLKS);
    localparam int CW          = $clog2(MAX_CLKS + 1);

    localparam logic [CW-1:0] ACC_LAST    = CW'(ACC_CLKS - 1);
    localparam logic [CW-1:0] ACC_WR_LAST = CW'(ACC_WR_CLKS - 1);
    localparam logic [CW-1:0] REF_LAST    = CW'(REF_CLKS - 1);
    localparam logic [CW-1:0] PRE_LAST    = CW'(PRE_CLKS - 1);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          wr_q, wr_d;
    logic          free;
    logic [CW-1:0] act_last;

    assign free     = (st_q == ST_IDLE) || ((st_q == ST_PRE) && (cnt_q == PRE_LAST));
    assign act_last = wr_q ? ACC_WR_LAST : ACC_LAST;

    always_comb begin
        nxt_st     = st_q;
        cnt_d      = cnt_q;
        nxt_bank   = bank_q;
        wr_d       = wr_q;
        accept_now = 1'b0;
        clr_now    = 1'b0;
        ref_take   = 1'b0;
        if (s_edge) begin
            if (free) begin
                cnt_d = '0;
                if (ref_pend) begin
                    nxt_st   = ST_RFR;
                    ref_take = 1'b1;
                end else if (pend_q || req_now) begin
                    nxt_st     = ST_ACT;
                    nxt_bank   = addr_b2;
                    wr_d       = 1'b0;
                    accept_now = !pend_q;
                end else begin
                    nxt_st = ST_IDLE;
                end
            end else begin
                case (st_q)
                    ST_ACT: begin
                        if (cnt_q == '0) begin
                            clr_now = 1'b1;
                            wr_d    = wr_dir;
                        end
                        if ((cnt_q != '0) && (cnt_q == act_last)) begin
                            nxt_st = ST_PRE;
                            cnt_d  = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                    ST_RFR: begin
                        if (cnt_q == REF_LAST) begin
                            nxt_st = ST_PRE;
                            cnt_d  = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                    ST_PRE: begin
                        cnt_d = cnt_q + 1'b1;
                    end
                    default: begin
                        nxt_st = ST_IDLE;
                        cnt_d  = '0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk2) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            bank_q <= 1'b0;
            wr_q   <= 1'b0;
        end else begin
            st_q   <= nxt_st;
            cnt_q  <= cnt_d;
            bank_q <= nxt_bank;
            wr_q   <= wr_d;
        end
    end

    // R9: an access or refresh is always followed by precharge
    assert_exit_via_pre_R9: assert property (@(posedge clk2) disable iff (rst)
        (st_q == ST_ACT || st_q == ST_RFR) |=> (st_q == $past(st_q) || st_q == ST_PRE));

    // R5: a pending refresh wins a free start edge
    assert_ref_wins_R5: assert property (@(posedge clk2) disable iff (rst)
        (s_edge && free && ref_pend) |=> (st_q == ST_RFR));

    // R8: a read never outlasts its nominal length
    assert_read_len_R8: assert property (@(posedge clk2) disable iff (rst)
        (st_q == ST_ACT && !wr_q) |-> (cnt_q <= ACC_LAST));

    // R4: the sequence only moves on start edges
    assert_state_on_start_R4: assert property (@(posedge clk2) disable iff (rst)
        (!s_edge) |=> $stable(st_q));

endmodule

// File: rtl/dseq_strobe_out.sv
module dseq_strobe_out import dseq_pkg::*; (
    input  logic       clk2,
    input  logic       rst,
    input  logic       s_edge,
    input  logic       m_edge,
    input  seq_st_e    st_q,
    input  seq_st_e    nxt_st,
    input  logic       nxt_bank,
    output logic [1:0] ras_n,
    output logic       row_sel,
    output logic       mux_en_n
);

    always_ff @(posedge clk2) begin
        if (rst) begin
            ras_n    <= RAS_ALL_OFF;
            row_sel  <= 1'b1;
            mux_en_n <= 1'b0;
        end else begin
            if (s_edge) begin
                ras_n <= ras_pattern(nxt_st, nxt_bank);
            end
            if (m_edge) begin
                row_sel  <= (st_q != ST_ACT);
                mux_en_n <= (st_q == ST_RFR);
            end
        end
    end

    // R4: strobes hold across middle edges
    assert_ras_start_only_R4: assert property (@(posedge clk2) disable iff (rst)
        m_edge |=> $stable(ras_n));

    // R4: multiplexer controls hold across start edges
    assert_mux_mid_only_R4: assert property (@(posedge clk2) disable iff (rst)
        s_edge |=> ($stable(row_sel) && $stable(mux_en_n)));

    // R6: the row address is presented when a strobe falls
    assert_row_at_fall_R6: assert property (@(posedge clk2) disable iff (rst)
        ($fell(ras_n[0]) || $fell(ras_n[1])) |-> row_sel);

    // R7: a refresh under way has the multiplexer switched off
    assert_mux_off_refresh_R7: assert property (@(posedge clk2) disable iff (rst)
        (ras_n == RAS_ALL_ON && $past(ras_n) == RAS_ALL_ON) |-> mux_en_n);

endmodule

// File: rtl/dram_ilv_seq.sv
module dram_ilv_seq import dseq_pkg::*; #(
    parameter int NSEL          = 5,
    parameter int ACC_CLKS      = 2,
    parameter int WR_EXTRA_CLKS = 1,
    parameter int REF_CLKS      = 2,
    parameter int PRE_CLKS      = 1
) (
    input  logic            clk2,
    input  logic            rst,
    input  logic            phase_mid,
    input  logic [NSEL-1:0] sel_n,
    input  logic            wr_dir,
    input  logic            addr_b2,
    input  logic            refresh_req,
    output logic [1:0]      ras_n,
    output logic            row_sel,
    output logic            mux_en_n,
    output logic            bank_q,
    output logic            pend_q
);

    edge_t   edg;
    logic    req_now;
    logic    accept_now;
    logic    clr_now;
    logic    ref_take;
    logic    ref_pend;
    logic    nxt_bank;
    seq_st_e st_q;
    seq_st_e nxt_st;

    assign edg.s_edge = !phase_mid;
    assign edg.m_edge = phase_mid;

    dseq_req_queue #(.NSEL(NSEL)) u_queue (
        .clk2       (clk2),
        .rst        (rst),
        .s_edge     (edg.s_edge),
        .sel_n      (sel_n),
        .accept_now (accept_now),
        .clr_now    (clr_now),
        .req_now    (req_now),
        .pend_q     (pend_q)
    );

    dseq_ref_latch u_ref (
        .clk2        (clk2),
        .rst         (rst),
        .m_edge      (edg.m_edge),
        .refresh_req (refresh_req),
        .ref_take    (ref_take),
        .ref_pend    (ref_pend)
    );

    dseq_core #(
        .ACC_CLKS      (ACC_CLKS),
        .WR_EXTRA_CLKS (WR_EXTRA_CLKS),
        .REF_CLKS      (REF_CLKS),
        .PRE_CLKS      (PRE_CLKS)
    ) u_core (
        .clk2       (clk2),
        .rst        (rst),
        .s_edge     (edg.s_edge),
        .req_now    (req_now),
        .pend_q     (pend_q),
        .ref_pend   (ref_pend),
        .addr_b2    (addr_b2),
        .wr_dir     (wr_dir),
        .st_q       (st_q),
        .nxt_st     (nxt_st),
        .bank_q     (bank_q),
        .nxt_bank   (nxt_bank),
        .accept_now (accept_now),
        .clr_now    (clr_now),
        .ref_take   (ref_take)
    );

    dseq_strobe_out u_out (
        .clk2     (clk2),
        .rst      (rst),
        .s_edge   (edg.s_edge),
        .m_edge   (edg.m_edge),
        .st_q     (st_q),
        .nxt_st   (nxt_st),
        .nxt_bank (nxt_bank),
        .ras_n    (ras_n),
        .row_sel  (row_sel),
        .mux_en_n (mux_en_n)
    );

    // R3: an access opens exactly one bank
    assert_one_bank_R3: assert property (@(posedge clk2) disable iff (rst)
        (st_q == ST_ACT) |-> ($countones(ras_n) == 1));

    // R3: the open bank matches the registered bank bit
    assert_bank_match_R3: assert property (@(posedge clk2) disable iff (rst)
        (st_q == ST_ACT) |-> (ras_n[bank_q] == 1'b0));

    // R3: the bank bit does not move during an access
    assert_bank_held_R3: assert property (@(posedge clk2) disable iff (rst)
        (st_q == ST_ACT && $past(st_q) == ST_ACT) |-> $stable(bank_q));

    // R5: a refresh drives both strobes
    assert_refresh_both_R5: assert property (@(posedge clk2) disable iff (rst)
        (st_q == ST_RFR) |-> (ras_n == RAS_ALL_ON));

    // R9: both strobes high during precharge
    assert_pre_high_R9: assert property (@(posedge clk2) disable iff (rst)
        (st_q == ST_PRE) |-> (ras_n == RAS_ALL_OFF));

endmodule

// File: tb/sim_dram_ilv_seq.sv
`timescale 1ns/1ps
module sim_dram_ilv_seq;

    localparam int NSEL = 3;
    localparam int ACC  = 2;
    localparam int WREX = 1;
    localparam int REFC = 2;
    localparam int PREC = 1;

    logic            clk2 = 1'b0;
    logic            rst = 1'b1;
    logic            phase_mid = 1'b0;
    logic [NSEL-1:0] sel_n = '1;
    logic            wr_dir = 1'b0;
    logic            addr_b2 = 1'b0;
    logic            refresh_req = 1'b0;
    logic [1:0]      ras_n;
    logic            row_sel;
    logic            mux_en_n;
    logic            bank_q;
    logic            pend_q;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    dram_ilv_seq #(
        .NSEL(NSEL), .ACC_CLKS(ACC), .WR_EXTRA_CLKS(WREX),
        .REF_CLKS(REFC), .PRE_CLKS(PREC)
    ) u0 (
        .clk2(clk2), .rst(rst), .phase_mid(phase_mid), .sel_n(sel_n),
        .wr_dir(wr_dir), .addr_b2(addr_b2), .refresh_req(refresh_req),
        .ras_n(ras_n), .row_sel(row_sel), .mux_en_n(mux_en_n),
        .bank_q(bank_q), .pend_q(pend_q)
    );

    always #4 clk2 = ~clk2;   // 125 MHz

    always @(posedge clk2) phase_mid <= ~phase_mid;

    // ---------------- behavioural reference ----------------
    int m_kind = 0;     // 0 none, 1 access, 2 refresh
    int m_on = 0;       // strobe clocks left
    int m_pre = 0;      // precharge clocks left
    int m_age = 0;      // processor clocks since launch
    int m_bank = 0;
    int m_pend = 0;
    int m_ref = 0;
    int e_ras = 3;
    int e_row = 1;
    int e_mux = 0;

    always @(posedge clk2) begin
        int p0;
        int req;
        int fresh;
        if (rst) begin
            m_kind = 0; m_on = 0; m_pre = 0; m_age = 0; m_bank = 0;
            m_pend = 0; m_ref = 0; e_ras = 3; e_row = 1; e_mux = 0;
        end else if (!phase_mid) begin
            p0 = m_pend;
            req = (sel_n == '0) ? 1 : 0;
            fresh = 0;
            if (m_kind != 0) begin
                m_age = m_age + 1;
                if (m_kind == 1 && m_age == 1) begin
                    if (wr_dir) m_on = m_on + WREX;
                    if (p0 != 0) m_pend = 0;
                end
                m_on = m_on - 1;
                if (m_on == 0) begin
                    m_kind = 0;
                    m_pre = PREC;
                end
            end else if (m_pre > 0) begin
                m_pre = m_pre - 1;
            end
            if (m_kind == 0 && m_pre == 0) begin
                if (m_ref != 0) begin
                    m_kind = 2; m_on = REFC; m_age = 0; m_ref = 0;
                end else if (p0 != 0 || req != 0) begin
                    m_kind = 1; m_on = ACC; m_age = 0; m_bank = addr_b2;
                    fresh = (p0 == 0) ? 1 : 0;
                end
            end
            if (req != 0 && p0 == 0 && fresh == 0) m_pend = 1;
            e_ras = (m_kind == 1) ? ((m_bank != 0) ? 1 : 2) : ((m_kind == 2) ? 0 : 3);
        end else begin
            if (refresh_req) m_ref = 1;
            e_row = (m_kind != 1) ? 1 : 0;
            e_mux = (m_kind == 2) ? 1 : 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // every-cycle comparison against the reference
    always @(negedge clk2) begin
        if (!rst && !done) begin
            chk("R4 ras_n vs model", int'(ras_n), e_ras);
            chk("R6 row_sel vs model", int'(row_sel), e_row);
            chk("R7 mux_en_n vs model", int'(mux_en_n), e_mux);
            chk("R3 bank_q vs model", int'(bank_q), m_bank);
            chk("R2 pend_q vs model", int'(pend_q), m_pend);
        end
    end

    // watchdog
    always @(posedge clk2) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk2);
    endtask

    task automatic wait_start;
        while (phase_mid != 1'b0) @(negedge clk2);
    endtask

    task automatic wait_mid;
        while (phase_mid != 1'b1) @(negedge clk2);
    endtask

    task automatic pulse_req(input bit bank, input bit wr);
        wait_start();
        sel_n = '0;
        addr_b2 = bank;
        wr_dir = wr;
        @(negedge clk2);
        sel_n = '1;
    endtask

    task automatic pulse_ref;
        wait_mid();
        refresh_req = 1'b1;
        @(negedge clk2);
        refresh_req = 1'b0;
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (ras_n != 2'b11 && n < 100) begin
            n++;
            @(negedge clk2);
        end
    endtask

    task automatic count_high(output int n);
        n = 0;
        while (ras_n == 2'b11 && n < 100) begin
            n++;
            @(negedge clk2);
        end
    endtask

    initial begin
        int n;
        rst = 1'b1;
        cycles(4);
        // R10: reset values
        chk("R10 ras_n", int'(ras_n), 3);
        chk("R10 row_sel", int'(row_sel), 1);
        chk("R10 mux_en_n", int'(mux_en_n), 0);
        chk("R10 bank_q", int'(bank_q), 0);
        chk("R10 pend_q", int'(pend_q), 0);
        rst = 1'b0;
        cycles(4);

        // R1: incomplete select set is ignored
        wait_start();
        sel_n = 3'b010;
        @(negedge clk2);
        sel_n = '1;
        cycles(5);
        chk("R1 partial select ras_n", int'(ras_n), 3);
        chk("R1 partial select pend_q", int'(pend_q), 0);

        // R3/R6/R8: read on bank 0
        pulse_req(1'b0, 1'b0);
        chk("R3 bank0 strobe", int'(ras_n), 2);
        chk("R6 row at strobe fall", int'(row_sel), 1);
        count_low(n);
        chk("R8 read strobe length", n, 2 * ACC);
        cycles(6);

        // R3/R8: write on bank 1
        pulse_req(1'b1, 1'b1);
        chk("R3 bank1 strobe", int'(ras_n), 1);
        count_low(n);
        chk("R8 write strobe length", n, 2 * (ACC + WREX));
        chk("R3 bank_q after write", int'(bank_q), 1);
        cycles(6);

        // R2/R9: request queued behind a read
        pulse_req(1'b0, 1'b0);
        pulse_req(1'b0, 1'b0);
        chk("R2 queued flag set", int'(pend_q), 1);
        count_low(n);
        count_high(n);
        chk("R9 precharge gap", n, 2 * PREC);
        chk("R2 queued launch strobe", int'(ras_n), 2);
        chk("R2 flag during first clock", int'(pend_q), 1);
        cycles(2);
        chk("R2 flag cleared", int'(pend_q), 0);
        cycles(8);

        // R5/R7: refresh when idle
        pulse_ref();
        @(negedge clk2);
        chk("R5 refresh both strobes", int'(ras_n), 0);
        @(negedge clk2);
        chk("R7 mux off in refresh", int'(mux_en_n), 1);
        cycles(10);

        // R5: refresh beats a queued access
        pulse_req(1'b0, 1'b0);
        pulse_ref();
        pulse_req(1'b1, 1'b0);
        chk("R2 queued under refresh", int'(pend_q), 1);
        count_low(n);
        count_high(n);
        chk("R9 gap before refresh", n, 2 * PREC);
        chk("R5 refresh ahead of queue", int'(ras_n), 0);
        cycles(20);

        // random mix, checked by the reference every cycle
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk2);
            sel_n = ($urandom_range(0, 4) == 0) ? '0 : NSEL'($urandom);
            addr_b2 = 1'($urandom);
            wr_dir = 1'($urandom);
            refresh_req = ($urandom_range(0, 30) == 0);
        end
        sel_n = '1;
        refresh_req = 1'b0;
        cycles(20);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule